// File: doc/BRIEF.md
# Dual-Channel Serial Port Interrupt and Status Controller

This block holds the register-side interrupt logic for a serial controller with two channels, A (console) and B (auxiliary). A processor reaches it through a small register bus with a one-cycle read or write strobe. Each channel has a status register, a command register and a holding register. One interrupt register answers reads with the latched status and takes writes as the enable mask. The character shift logic, the baud rate source and the counter/timer are outside this block. Only their flags, strobes and data reach it.

Each channel reports a character arrival with a one-cycle strobe. If that channel's receive enable is set, a sticky receive-ready bit is recorded and the interrupt line rises. A free-running divider counts pulses on a periodic tick input. On every second pulse it marks both transmitters ready, provided either transmit enable is set, so that output keeps draining. The interrupt line is a level. Only a read of channel A's status register drops it. Status bits clear on holding-register traffic. When a set and a clear reach the same bit in one cycle, the set wins.

Register addresses on `bus_addr`: 0 status A, 1 command A, 2 holding A, 3 status B, 4 command B, 5 holding B, 6 interrupt status/mask, 7 unused.

Top module: `duart_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status register, the mask and the tick counter are zero and `irq` is low.
- R2: A write to address 6 loads the mask from `bus_wdata`. A read of address 6 returns the status register, never the mask. Status bit positions: 0 transmit-ready A, 1 receive-ready A, 4 transmit-ready B, 5 receive-ready B. All other bits read 0.
- R3: A `rx_arrive_a` (or `rx_arrive_b`) strobe with mask bit 1 (or bit 5) set sets status bit 1 (or bit 5) and raises `irq` from the next cycle. With the mask bit clear, the strobe changes nothing.
- R4: A read of address 0 (or 3) returns bit 0 = `rx_avail_a` (or `rx_avail_b`) and bit 2 = 1. All other bits are 0.
- R5: `irq` stays high until a read of address 0 with no set event in the same cycle, after which it is low. A read of address 3 leaves `irq` unchanged. Status reads leave the status bits unchanged.
- R6: A read of address 2 (or 5) returns `rx_data_a` (or `rx_data_b`), pulses `rx_pop_a` (or `rx_pop_b`) in that cycle, and clears status bit 1 (or bit 5).
- R7: A write to address 2 (or 5) pulses `tx_wr_a` (or `tx_wr_b`) with `tx_data` equal to `bus_wdata`. A write to either address clears status bit 0 only, and bit 4 is left as it was.
- R8: On every second `tx_tick` pulse after reset, the tick counter returns to zero. If mask bit 0 or bit 4 is set, status bits 0 and 4 are set and `irq` rises. Otherwise nothing else changes.
- R9: A write to address 1 (or 4) with bit 3 set pulses `flush_a` (or `flush_b`) in that cycle. Without bit 3, no flush pulse is produced.
- R10: A set event and a clear event that hit the same status bit in one cycle leave the bit set.
- R11: Reads of addresses 1, 4 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| rx_avail_a | input | 1 | Channel A has a received character waiting |
| rx_avail_b | input | 1 | Channel B has a received character waiting |
| rx_data_a | input | 8 | Channel A received character |
| rx_data_b | input | 8 | Channel B received character |
| rx_arrive_a | input | 1 | Channel A character arrival strobe |
| rx_arrive_b | input | 1 | Channel B character arrival strobe |
| tx_tick | input | 1 | Periodic tick pulse for the transmit-ready divider |
| irq | output | 1 | Interrupt request, level |
| rx_pop_a | output | 1 | Channel A receive character consumed |
| rx_pop_b | output | 1 | Channel B receive character consumed |
| tx_wr_a | output | 1 | Channel A transmit character write |
| tx_wr_b | output | 1 | Channel B transmit character write |
| tx_data | output | 8 | Transmit character |
| flush_a | output | 1 | Channel A transmit flush request |
| flush_b | output | 1 | Channel B transmit flush request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that a rising receive-ready or transmit-ready bit can only follow an arrival strobe or a tick pulse. The random stimulus draws at most one bus access per cycle, so the first assumption always holds. Arrival strobes and tick pulses are drawn independently of bus traffic, so set and clear events collide often enough to exercise the set-wins rule.

// File: rtl/duart_irq_pkg.sv
// Package: shared register addresses, bit positions and the decoded-access type
// for the dual-channel interrupt controller. Assumes an 8-bit register bus.
package duart_irq_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_STAT_A = 3'd0,
        RA_CMD_A  = 3'd1,
        RA_HOLD_A = 3'd2,
        RA_STAT_B = 3'd3,
        RA_CMD_B  = 3'd4,
        RA_HOLD_B = 3'd5,
        RA_INT    = 3'd6,
        RA_SPARE  = 3'd7
    } reg_addr_e;

    // Interrupt status / mask bit positions (software decodes these)
    localparam int BIT_TX_A = 0;
    localparam int BIT_RX_A = 1;
    localparam int BIT_TX_B = 4;
    localparam int BIT_RX_B = 5;

    // Channel status register bit positions
    localparam int ST_RX_AVAIL = 0;
    localparam int ST_TX_RDY   = 2;

    // Command register flush request bit
    localparam int CMD_FLUSH = 3;

    localparam int NUM_CH = 2;

    // One-hot decoded register access for one cycle
    typedef struct packed {
        logic stat_a_rd;
        logic stat_b_rd;
        logic int_rd;
        logic int_wr;
        logic [NUM_CH-1:0] hold_rd;
        logic [NUM_CH-1:0] hold_wr;
        logic [NUM_CH-1:0] flush;
    } acc_t;

endpackage

// File: rtl/duart_reg_decode.sv
// Module: turns a bus strobe and address into one-cycle access flags.
// Assumes read and write strobes are never high together.
module duart_reg_decode
    import duart_irq_pkg::*;
(
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  flush_bit,
    output acc_t                  acc
);

    // Decode the access type from address and strobe
    always_comb begin
        acc = '0;
        case (reg_addr_e'(bus_addr))
            RA_STAT_A: acc.stat_a_rd  = bus_rd;
            RA_STAT_B: acc.stat_b_rd  = bus_rd;
            RA_HOLD_A: begin
                acc.hold_rd[0] = bus_rd;
                acc.hold_wr[0] = bus_wr;
            end
            RA_HOLD_B: begin
                acc.hold_rd[1] = bus_rd;
                acc.hold_wr[1] = bus_wr;
            end
            RA_CMD_A:  acc.flush[0] = bus_wr & flush_bit;
            RA_CMD_B:  acc.flush[1] = bus_wr & flush_bit;
            RA_INT: begin
                acc.int_rd = bus_rd;
                acc.int_wr = bus_wr;
            end
            default: acc = '0;
        endcase
    end

endmodule

// File: rtl/duart_tick_div.sv
// Module: counts periodic tick pulses and fires on every TICK_DIV-th one,
// then restarts from zero. Assumes TICK_DIV >= 2.
module duart_tick_div #(
    parameter int TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic fire_o
);

    localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Fire on the tick that completes the division period
    assign fire_o = tick_i && (cnt_q == LAST);

    // Advance the tick counter, wrapping after the last count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/duart_isr_core.sv
// Module: holds the interrupt mask, the sticky interrupt status and the
// interrupt level. Set events beat clear events on the same bit.
// Assumes one-cycle access flags from the decoder.
module duart_isr_core
    import duart_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_t              acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] rx_arrive,
    input  logic              tx_fire,
    output logic [DATA_W-1:0] isr,
    output logic              irq
);

    localparam int RX_POS [NUM_CH] = '{BIT_RX_A, BIT_RX_B};
    localparam logic [DATA_W-1:0] TX_BITS =
        DATA_W'((1 << BIT_TX_A) | (1 << BIT_TX_B));

    logic [DATA_W-1:0] imr_q;
    logic [DATA_W-1:0] isr_q;
    logic              irq_q;
    logic [DATA_W-1:0] rx_req;
    logic [DATA_W-1:0] rx_clr;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic              tx_en;

    // Place each channel's arrival and pop events at its status position
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_comb begin
            rx_req[RX_POS[ch]] = rx_arrive[ch];
            rx_clr[RX_POS[ch]] = acc.hold_rd[ch];
        end
    end

    // Fill the non-receive positions of the event vectors with zero
    always_comb begin
        for (int b = 0; b < DATA_W; b++) begin
            if (b != BIT_RX_A && b != BIT_RX_B) begin
                rx_req[b] = 1'b0;
                rx_clr[b] = 1'b0;
            end
        end
    end

    // Gate set events by the mask and gather clear events
    always_comb begin
        tx_en   = |(imr_q & TX_BITS);
        set_vec = (rx_req & imr_q) | ((tx_fire && tx_en) ? TX_BITS : '0);
        clr_vec = rx_clr;
        // Either holding write clears the channel A transmit bit only
        clr_vec[BIT_TX_A] = |acc.hold_wr;
    end

    // Update mask, sticky status and interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q <= '0;
            isr_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (acc.int_wr) begin
                imr_q <= wdata;
            end
            isr_q <= (isr_q & ~clr_vec) | set_vec;
            if (|set_vec) begin
                irq_q <= 1'b1;
            end else if (acc.stat_a_rd) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign isr = isr_q;
    assign irq = irq_q;

endmodule

// File: rtl/duart_irq_ctrl.sv
// Module: top of the dual-channel serial interrupt controller. Decodes the
// register bus, returns read data in the strobe cycle and routes the
// channel strobes. Assumes bus_rd and bus_wr are exclusive.
module duart_irq_ctrl
    import duart_irq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TICK_DIV = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  rx_avail_a,
    input  logic                  rx_avail_b,
    input  logic [DATA_W-1:0]     rx_data_a,
    input  logic [DATA_W-1:0]     rx_data_b,
    input  logic                  rx_arrive_a,
    input  logic                  rx_arrive_b,
    input  logic                  tx_tick,
    output logic                  irq,
    output logic                  rx_pop_a,
    output logic                  rx_pop_b,
    output logic                  tx_wr_a,
    output logic                  tx_wr_b,
    output logic [DATA_W-1:0]     tx_data,
    output logic                  flush_a,
    output logic                  flush_b
);

    acc_t              acc;
    logic              tx_fire;
    logic [DATA_W-1:0] isr_w;

    duart_reg_decode u_dec (
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .flush_bit (bus_wdata[CMD_FLUSH]),
        .acc       (acc)
    );

    duart_tick_div #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tx_tick),
        .fire_o (tx_fire)
    );

    duart_isr_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .wdata     (bus_wdata),
        .rx_arrive ({rx_arrive_b, rx_arrive_a}),
        .tx_fire   (tx_fire),
        .isr       (isr_w),
        .irq       (irq)
    );

    // Build a channel status byte from its receive flag
    function automatic logic [DATA_W-1:0] chan_status(input logic avail);
        logic [DATA_W-1:0] s;
        s = '0;
        s[ST_RX_AVAIL] = avail;
        s[ST_TX_RDY]   = 1'b1;
        return s;
    endfunction

    // Select read data for the addressed register
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (reg_addr_e'(bus_addr))
                RA_STAT_A: bus_rdata = chan_status(rx_avail_a);
                RA_STAT_B: bus_rdata = chan_status(rx_avail_b);
                RA_HOLD_A: bus_rdata = rx_data_a;
                RA_HOLD_B: bus_rdata = rx_data_b;
                RA_INT:    bus_rdata = isr_w;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // Route per-channel strobes to the serial side
    assign rx_pop_a = acc.hold_rd[0];
    assign rx_pop_b = acc.hold_rd[1];
    assign tx_wr_a  = acc.hold_wr[0];
    assign tx_wr_b  = acc.hold_wr[1];
    assign tx_data  = bus_wdata;
    assign flush_a  = acc.flush[0];
    assign flush_b  = acc.flush[1];

endmodule

// File: rtl/duart_irq_ctrl_chk.sv
// Checker: temporal properties of the interrupt controller, bound to the top.
// Assumes exclusive read/write strobes.
module duart_irq_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [2:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] isr_w,
    input logic              irq,
    input logic              rx_arrive_a,
    input logic              rx_arrive_b,
    input logic              tx_tick,
    input logic              flush_a,
    input logic              flush_b
);

    p_status_a_clears_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd0 && !rx_arrive_a && !rx_arrive_b && !tx_tick) |=> !irq);

    p_status_b_keeps_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd3 && irq) |=> irq);

    p_rx_a_needs_arrival_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_w[1]) |-> ($past(rx_arrive_a) && irq));

    p_rx_b_needs_arrival_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_w[5]) |-> ($past(rx_arrive_b) && irq));

    p_tx_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_w[4]) |-> ($past(tx_tick) && isr_w[0]));

    p_hold_a_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd2 && !rx_arrive_a) |=> !isr_w[1]);

    p_hold_write_clears_tx_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 3'd2 || bus_addr == 3'd5) && !tx_tick) |=> !isr_w[0]);

    p_unused_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_w[3:2] == 2'b00) && (isr_w[7:6] == 2'b00));

    p_status_read_tx_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == 3'd0 || bus_addr == 3'd3)) |-> bus_rdata[2]);

    p_single_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_a, flush_b}) && !(bus_rd && bus_wr));

endmodule

bind duart_irq_ctrl duart_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .isr_w       (isr_w),
    .irq         (irq),
    .rx_arrive_a (rx_arrive_a),
    .rx_arrive_b (rx_arrive_b),
    .tx_tick     (tx_tick),
    .flush_a     (flush_a),
    .flush_b     (flush_b)
);

// File: tb/duart_irq_ctrl_tb_top.sv
// Bench: directed corner cases then seeded random traffic, checked against a
// reference model kept in bench variables.
module duart_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_rd, bus_wr;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       rx_avail_a, rx_avail_b;
    logic [7:0] rx_data_a, rx_data_b;
    logic       rx_arrive_a, rx_arrive_b, tx_tick;
    logic       irq, rx_pop_a, rx_pop_b, tx_wr_a, tx_wr_b, flush_a, flush_b;
    logic [7:0] tx_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference model state
    logic [7:0] m_isr, m_imr;
    logic       m_irq;
    int         m_tcnt;

    always #2.5 clk = ~clk;

    duart_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_avail_a(rx_avail_a), .rx_avail_b(rx_avail_b),
        .rx_data_a(rx_data_a), .rx_data_b(rx_data_b),
        .rx_arrive_a(rx_arrive_a), .rx_arrive_b(rx_arrive_b), .tx_tick(tx_tick),
        .irq(irq), .rx_pop_a(rx_pop_a), .rx_pop_b(rx_pop_b),
        .tx_wr_a(tx_wr_a), .tx_wr_b(tx_wr_b), .tx_data(tx_data),
        .flush_a(flush_a), .flush_b(flush_b)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0:    return 8'h04 | {7'd0, rx_avail_a};
            3'd3:    return 8'h04 | {7'd0, rx_avail_b};
            3'd2:    return rx_data_a;
            3'd5:    return rx_data_b;
            3'd6:    return m_isr;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0, 3'd3: return "R4 status read";
            3'd2, 3'd5: return "R6 holding read";
            3'd6:       return "R2 interrupt status read";
            default:    return "R11 unused read";
        endcase
    endfunction

    task automatic model_reset();
        m_isr = 8'h00; m_imr = 8'h00; m_irq = 1'b0; m_tcnt = 0;
    endtask

    // One bus cycle: drive at negedge, check strobes, update model at posedge
    task automatic cyc(input logic rd, input logic wr, input logic [2:0] a,
                       input logic [7:0] wd, input logic arr_a, input logic arr_b,
                       input logic tk, input string tag);
        logic [7:0] set_v, clr_v;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        rx_arrive_a = arr_a; rx_arrive_b = arr_b; tx_tick = tk;
        #1;
        if (rd) check(tag == "" ? rd_tag(a) : tag, bus_rdata, exp_rdata(a));
        check("R9 flush strobes", {6'd0, flush_b, flush_a},
              {6'd0, wr && a == 3'd4 && wd[3], wr && a == 3'd1 && wd[3]});
        check("R6 pop strobes", {6'd0, rx_pop_b, rx_pop_a},
              {6'd0, rd && a == 3'd5, rd && a == 3'd2});
        check("R7 tx strobes", {6'd0, tx_wr_b, tx_wr_a},
              {6'd0, wr && a == 3'd5, wr && a == 3'd2});
        if (wr) check("R7 tx data", tx_data, wd);
        set_v = 8'h00;
        clr_v = 8'h00;
        if (arr_a && m_imr[1]) set_v |= 8'h02;
        if (arr_b && m_imr[5]) set_v |= 8'h20;
        if (tk) begin
            m_tcnt++;
            if (m_tcnt == 2) begin
                m_tcnt = 0;
                if ((m_imr & 8'h11) != 0) set_v |= 8'h11;
            end
        end
        if (rd && a == 3'd2) clr_v |= 8'h02;
        if (rd && a == 3'd5) clr_v |= 8'h20;
        if (wr && (a == 3'd2 || a == 3'd5)) clr_v |= 8'h01;
        m_isr = (m_isr & ~clr_v) | set_v;
        if (set_v != 0) m_irq = 1'b1;
        else if (rd && a == 3'd0) m_irq = 1'b0;
        if (wr && a == 3'd6) m_imr = wd;
        @(posedge clk);
        #1;
        check("R5 irq level", {7'd0, irq}, {7'd0, m_irq});
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 3'd7, 8'h00, 1'b0, 1'b0, 1'b0, "");
    endtask

    task automatic read_isr(input string tag);
        cyc(1'b1, 1'b0, 3'd6, 8'h00, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        rx_avail_a = 0; rx_avail_b = 1; rx_data_a = 8'h5A; rx_data_b = 8'hC3;
        rx_arrive_a = 0; rx_arrive_b = 0; tx_tick = 0;
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        read_isr("R1 status after reset");
        // R3: arrival with mask clear does nothing
        cyc(0, 0, 3'd7, 8'h00, 1, 1, 0, "");
        read_isr("R3 masked arrival ignored");
        // R8: tick with transmit enables clear does nothing
        cyc(0, 0, 3'd7, 8'h00, 0, 0, 1, "");
        cyc(0, 0, 3'd7, 8'h00, 0, 0, 1, "");
        read_isr("R8 tick without enable");
        // R2: load mask, read back is the status
        cyc(0, 1, 3'd6, 8'h33, 0, 0, 0, "");
        read_isr("R2 mask not readable");
        // R3: enabled arrival on A
        cyc(0, 0, 3'd7, 8'h00, 1, 0, 0, "");
        read_isr("R3 receive-ready A set");
        // R5: channel B status leaves irq high, channel A status drops it
        rx_avail_a = 1;
        cyc(1, 0, 3'd3, 8'h00, 0, 0, 0, "R4 status B");
        check("R5 irq kept by status B", {7'd0, irq}, 8'h01);
        cyc(1, 0, 3'd0, 8'h00, 0, 0, 0, "R4 status A with data");
        check("R5 irq cleared by status A", {7'd0, irq}, 8'h00);
        read_isr("R5 status bits kept");
        // R6: holding read A clears receive-ready A
        cyc(1, 0, 3'd2, 8'h00, 0, 0, 0, "R6 holding A data");
        read_isr("R6 receive-ready A cleared");
        // R8: two ticks with enables set both transmit bits
        cyc(0, 0, 3'd7, 8'h00, 0, 0, 1, "");
        read_isr("R8 first tick no effect");
        cyc(0, 0, 3'd7, 8'h00, 0, 0, 1, "");
        read_isr("R8 second tick sets transmit bits");
        // R7: holding write B clears transmit-ready A only
        cyc(0, 1, 3'd5, 8'h41, 0, 0, 0, "");
        read_isr("R7 only transmit A cleared");
        // R10: arrival and pop on the same cycle
        cyc(1, 0, 3'd5, 8'h00, 0, 1, 0, "R6 holding B data");
        read_isr("R10 set wins over clear");
        // R9 / R11
        cyc(0, 1, 3'd1, 8'h08, 0, 0, 0, "");
        cyc(0, 1, 3'd4, 8'h0F, 0, 0, 0, "");
        cyc(0, 1, 3'd1, 8'h07, 0, 0, 0, "");
        cyc(1, 0, 3'd1, 8'h00, 0, 0, 0, "R11 command A reads zero");
        cyc(1, 0, 3'd7, 8'h00, 0, 0, 0, "R11 spare reads zero");
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [2:0] a;
            op = $urandom_range(0, 2);
            a  = 3'($urandom_range(0, 7));
            rx_avail_a = 1'($urandom);
            rx_avail_b = 1'($urandom);
            rx_data_a  = 8'($urandom);
            rx_data_b  = 8'($urandom);
            cyc(op == 1, op == 2, a, 8'($urandom),
                ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 2) == 0), "");
        end
        // Reset mid-run restores R1 state
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        check("R1 irq after second reset", {7'd0, irq}, 8'h00);
        read_isr("R1 status after second reset");
        idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule